// File: doc/BRIEF.md
# Key-Guarded Chip Control Register

This block holds an 8-bit chip control register that software can read at any time but can only change after a two-write unlock handshake on a separate key register. A write of 0x87 followed by a write of 0x59 to the key address opens the guard. Any other value written to the key address shuts it again. The guard also closes on reset and after a software reset.

The control register drives three things. The first is an enable for the on-chip auxiliary RAM. The second is a request to switch into programming mode at the next wake-up from idle, signalled by a one-cycle entry pulse when that wake-up arrives. The third is a software reset. Writing a value with bits 0, 1 and 7 all set fires a one-cycle reset pulse toward the reset network. The block then clears itself exactly as an external reset would.

Both registers sit on a simple byte-wide register bus with an address, a write strobe, write data and combinational read data.

Top module: `ctl_guard`

## Requirements
- R1: After reset the control register reads 0x00, the key register reads 0x00, and `aux_ram_en_o`, `isp_req_o`, `isp_enter_o` and `sw_rst_o` are all low.
- R2: While the guard is closed, a write to the control address leaves the control register unchanged.
- R3: A write of 0x87 and then a write of 0x59 to the key address opens the guard. Only key-address writes count toward the sequence. The key register then reads 0x01 (bit 0 = open), and control writes take effect on the next clock edge.
- R4: A 0x59 written while the guard is closed and not armed by a preceding 0x87 leaves it closed. A 0x87 followed by any key value other than 0x59 or 0x87 also leaves it closed.
- R5: With the guard open, writing any key value other than 0x87 or 0x59 closes it. Writing 0x87 or 0x59 keeps it open.
- R6: `aux_ram_en_o` equals bit 4 of the control register.
- R7: `isp_req_o` equals bit 0 of the control register. One cycle after `wake_i` is high with bit 0 set, `isp_enter_o` is high for exactly that one cycle. With bit 0 clear, `wake_i` produces no pulse.
- R8: Take an open-guard control write whose data has bits 0, 1 and 7 all set. It makes `sw_rst_o` high for exactly the one cycle after the write edge. In that same cycle the control register reads 0x00 and the guard is closed. A value with only bits 0 and 1 set is stored normally and issues no pulse.
- R9: Writes to other addresses change neither register nor the guard, and reads of other addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Register bus address |
| we_i | input | 1 | Write strobe, sampled on the rising clock edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| wake_i | input | 1 | Idle wake-up event, one cycle |
| aux_ram_en_o | output | 1 | Auxiliary RAM enable |
| isp_req_o | output | 1 | Programming mode requested for the next wake-up |
| isp_enter_o | output | 1 | One-cycle pulse: enter programming mode now |
| sw_rst_o | output | 1 | One-cycle software reset pulse |

## Verification
The bench tries out-of-order keys:
- A lone 0x59 must not unlock. A design that opened on 0x59 in any state would accept a single-write unlock.
- A 0x87 followed by a stray value must not unlock. A design that remembered a half sequence across a closing write would accept it.

The bench checks that the guard stays open across repeated key values and across several control writes. A design that closed after one write, or on a second 0x87, is caught there.

For the software reset, it checks the exact one-cycle pulse and the cleared register and guard. It also checks that the near-miss value 0x03 is stored without a pulse, which catches a decoder that tests too few bits.

It checks the wake-up pulse with bit 0 set and with bit 0 clear, and it checks that a stray address neither reads back data nor alters state.

// File: rtl/ctl_lock_pkg.sv
package ctl_lock_pkg;
  typedef enum logic [1:0] {
    LK_CLOSED = 2'd0,
    LK_ARMED  = 2'd1,
    LK_OPEN   = 2'd2
  } lock_state_e;

  // control bit positions decoded by neighbours
  localparam int unsigned ISP_BIT  = 0;
  localparam int unsigned RST1_BIT = 1;
  localparam int unsigned AUX_BIT  = 4;
  localparam int unsigned RST7_BIT = 7;
endpackage

// File: rtl/key_gate.sv
module key_gate
  import ctl_lock_pkg::*;
#(
  parameter int unsigned      DATA_W     = 8,
  parameter logic [DATA_W-1:0] KEY_FIRST  = 8'h87,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'h59
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              key_we_i,
  input  logic [DATA_W-1:0] key_data_i,
  input  logic              relock_i,
  output logic              open_o,
  output logic              armed_o
);
  lock_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (key_data_i == KEY_FIRST) begin
      state_d = (state_q == LK_OPEN) ? LK_OPEN : LK_ARMED;
    end else if (key_data_i == KEY_SECOND) begin
      state_d = (state_q == LK_CLOSED) ? LK_CLOSED : LK_OPEN;
    end else begin
      state_d = LK_CLOSED;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       state_q <= LK_CLOSED;
    else if (relock_i) state_q <= LK_CLOSED;
    else if (key_we_i) state_q <= state_d;
  end

  assign open_o  = (state_q == LK_OPEN);
  assign armed_o = (state_q == LK_ARMED);
endmodule

// File: rtl/ctl_store.sv
module ctl_store
  import ctl_lock_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] ctl_o,
  output logic              soft_clr_o,
  output logic              soft_rst_o
);
  localparam logic [DATA_W-1:0] RST_MASK =
    DATA_W'((1 << ISP_BIT) | (1 << RST1_BIT) | (1 << RST7_BIT));

  logic [DATA_W-1:0] ctl_q;
  logic              pulse_q;

  assign soft_clr_o = wr_i && ((wdata_i & RST_MASK) == RST_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= soft_clr_o;
      if (soft_clr_o) ctl_q <= '0;
      else if (wr_i)  ctl_q <= wdata_i;
    end
  end

  assign ctl_o      = ctl_q;
  assign soft_rst_o = pulse_q;
endmodule

// File: rtl/isp_wake.sv
module isp_wake (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wake_i,
  input  logic arm_i,
  output logic enter_o
);
  logic enter_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) enter_q <= 1'b0;
    else         enter_q <= wake_i && arm_i;
  end

  assign enter_o = enter_q;
endmodule

// File: rtl/ctl_guard.sv
module ctl_guard
  import ctl_lock_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 8,
  parameter int unsigned       DATA_W     = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR   = 8'h40,
  parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'h41,
  parameter logic [DATA_W-1:0] KEY_FIRST  = 8'h87,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'h59
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              wake_i,
  output logic              aux_ram_en_o,
  output logic              isp_req_o,
  output logic              isp_enter_o,
  output logic              sw_rst_o
);
  logic              key_we, ctl_we, unlocked, armed, relock;
  logic [DATA_W-1:0] ctl_q;

  assign key_we = we_i && (addr_i == KEY_ADDR);
  assign ctl_we = we_i && (addr_i == CTL_ADDR) && unlocked;

  key_gate #(
    .DATA_W(DATA_W), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
  ) i_key_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .key_we_i(key_we), .key_data_i(wdata_i),
    .relock_i(relock), .open_o(unlocked), .armed_o(armed)
  );

  ctl_store #(.DATA_W(DATA_W)) i_ctl_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(ctl_we), .wdata_i(wdata_i),
    .ctl_o(ctl_q), .soft_clr_o(relock), .soft_rst_o(sw_rst_o)
  );

  isp_wake i_isp_wake (
    .clk_i(clk_i), .rst_ni(rst_ni), .wake_i(wake_i),
    .arm_i(ctl_q[ISP_BIT]), .enter_o(isp_enter_o)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == CTL_ADDR)      rdata_o = ctl_q;
    else if (addr_i == KEY_ADDR) rdata_o = DATA_W'(unlocked);
  end

  assign aux_ram_en_o = ctl_q[AUX_BIT];
  assign isp_req_o    = ctl_q[ISP_BIT];
endmodule

// File: rtl/ctl_guard_chk.sv
module ctl_guard_chk
  import ctl_lock_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 8,
  parameter int unsigned       DATA_W     = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR   = 8'h40,
  parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'h41,
  parameter logic [DATA_W-1:0] KEY_FIRST  = 8'h87,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'h59
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              wake_i,
  input logic [DATA_W-1:0] ctl_q,
  input logic              unlocked,
  input logic              armed,
  input logic              sw_rst_o,
  input logic              isp_enter_o
);
  logic key_wr;
  assign key_wr = we_i && (addr_i == KEY_ADDR);

  p_locked_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == CTL_ADDR && !unlocked) |=> (ctl_q == $past(ctl_q)));

  p_unlock_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_wr && armed && wdata_i == KEY_SECOND) |=> unlocked);

  p_stray_second_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_wr && !armed && !unlocked && wdata_i == KEY_SECOND) |=> !unlocked);

  p_close_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_wr && wdata_i != KEY_FIRST && wdata_i != KEY_SECOND) |=> !unlocked);

  p_isp_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    isp_enter_o |-> ($past(wake_i) && $past(ctl_q[ISP_BIT])));

  p_srst_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_o |=> !sw_rst_o);

  p_srst_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_o |-> (ctl_q == '0 && !unlocked));
endmodule

bind ctl_guard ctl_guard_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTL_ADDR(CTL_ADDR), .KEY_ADDR(KEY_ADDR),
  .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
) i_ctl_guard_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
  .wdata_i(wdata_i), .wake_i(wake_i), .ctl_q(ctl_q), .unlocked(unlocked),
  .armed(armed), .sw_rst_o(sw_rst_o), .isp_enter_o(isp_enter_o)
);

// File: tb/test_ctl_guard.sv
module test_ctl_guard;
  localparam int unsigned CLK_PERIOD = 10;
  localparam logic [7:0] A_CTL = 8'h40;
  localparam logic [7:0] A_KEY = 8'h41;
  localparam logic [7:0] A_OTHER = 8'h22;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] addr_i = '0;
  logic       we_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       wake_i = 1'b0;
  logic       aux_ram_en_o, isp_req_o, isp_enter_o, sw_rst_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  ctl_guard i_ctl_guard (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .wake_i(wake_i),
    .aux_ram_en_o(aux_ram_en_o), .isp_req_o(isp_req_o),
    .isp_enter_o(isp_enter_o), .sw_rst_o(sw_rst_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic unlock();
    wr(A_KEY, 8'h87);
    wr(A_KEY, 8'h59);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(A_CTL, v); check("R1 ctl", v, 8'h00);
    rd(A_KEY, v); check("R1 key", v, 8'h00);
    check("R1 outs", {4'h0, aux_ram_en_o, isp_req_o, isp_enter_o, sw_rst_o}, 8'h00);
  endtask

  task automatic t_locked();
    logic [7:0] v;
    wr(A_CTL, 8'h10);
    rd(A_CTL, v); check("R2 locked write", v, 8'h00);
    check("R2 aux", {7'h0, aux_ram_en_o}, 8'h00);
  endtask

  task automatic t_unlock();
    logic [7:0] v;
    wr(A_KEY, 8'h87);
    wr(A_CTL, 8'h55);
    rd(A_CTL, v); check("R2 armed write", v, 8'h00);
    wr(A_KEY, 8'h59);
    rd(A_KEY, v); check("R3 key open", v, 8'h01);
    wr(A_CTL, 8'h10);
    rd(A_CTL, v); check("R3 ctl write", v, 8'h10);
    check("R6 aux on", {7'h0, aux_ram_en_o}, 8'h01);
    wr(A_CTL, 8'h00);
    rd(A_CTL, v); check("R3 second write", v, 8'h00);
    check("R6 aux off", {7'h0, aux_ram_en_o}, 8'h00);
    wr(A_KEY, 8'h00);
    rd(A_KEY, v); check("R5 close", v, 8'h00);
  endtask

  task automatic t_bad_seq();
    logic [7:0] v;
    wr(A_KEY, 8'h59);
    rd(A_KEY, v); check("R4 lone second", v, 8'h00);
    wr(A_KEY, 8'h87);
    wr(A_KEY, 8'h33);
    wr(A_KEY, 8'h59);
    rd(A_KEY, v); check("R4 broken seq", v, 8'h00);
    wr(A_CTL, 8'h10);
    rd(A_CTL, v); check("R4 ctl unchanged", v, 8'h00);
  endtask

  task automatic t_close();
    logic [7:0] v;
    unlock();
    wr(A_KEY, 8'h87);
    rd(A_KEY, v); check("R5 keep on first", v, 8'h01);
    wr(A_KEY, 8'h59);
    rd(A_KEY, v); check("R5 keep on second", v, 8'h01);
    wr(A_KEY, 8'hFF);
    rd(A_KEY, v); check("R5 close on ff", v, 8'h00);
    wr(A_CTL, 8'h10);
    rd(A_CTL, v); check("R5 ctl after close", v, 8'h00);
  endtask

  task automatic t_isp();
    unlock();
    wr(A_CTL, 8'h01);
    check("R7 req", {7'h0, isp_req_o}, 8'h01);
    @(negedge clk_i); wake_i = 1'b1;
    @(negedge clk_i); wake_i = 1'b0;
    check("R7 enter pulse", {7'h0, isp_enter_o}, 8'h01);
    @(negedge clk_i);
    check("R7 pulse ends", {7'h0, isp_enter_o}, 8'h00);
    wr(A_CTL, 8'h00);
    @(negedge clk_i); wake_i = 1'b1;
    @(negedge clk_i); wake_i = 1'b0;
    check("R7 no pulse", {7'h0, isp_enter_o}, 8'h00);
  endtask

  task automatic t_srst();
    logic [7:0] v;
    wr(A_CTL, 8'h03);
    rd(A_CTL, v); check("R8 near miss stored", v, 8'h03);
    check("R8 near miss no pulse", {7'h0, sw_rst_o}, 8'h00);
    wr(A_CTL, 8'h93);
    check("R8 pulse", {7'h0, sw_rst_o}, 8'h01);
    rd(A_CTL, v); check("R8 ctl cleared", v, 8'h00);
    rd(A_KEY, v); check("R8 relocked", v, 8'h00);
    @(negedge clk_i);
    check("R8 single cycle", {7'h0, sw_rst_o}, 8'h00);
  endtask

  task automatic t_other();
    logic [7:0] v;
    unlock();
    wr(A_CTL, 8'h10);
    wr(A_OTHER, 8'hFF);
    rd(A_OTHER, v); check("R9 other read", v, 8'h00);
    rd(A_CTL, v); check("R9 ctl kept", v, 8'h10);
    rd(A_KEY, v); check("R9 guard kept", v, 8'h01);
    wr(A_KEY, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_locked();
    t_unlock();
    t_bad_seq();
    t_close();
    t_isp();
    t_srst();
    t_other();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule